// File: doc/BRIEF.md
# Cascaded DMA Channel Mask Logic

This block keeps the request mask state for two cascaded four-channel DMA controllers, which together serve eight channels. A byte-wide I/O port interface reaches three operations on each controller: a master clear, a clear of all four masks, and a load or readback of all four masks at once. A master clear acts like a hardware reset on its own controller. It sets all four masks of that controller and sends a one-cycle pulse that tells the neighbouring register blocks to clear their command, status, request and byte-pointer state.

A channel's mask also sets by itself when that channel reports terminal count, unless the channel runs in auto-initialization mode. The block gates the raw DMA request lines with the masks to produce the effective requests. The low controller reaches the system through channel 4 of the high controller, so masking channel 4 also blocks channels 0 to 3.

Top module: `dma_mask_pair`

## Requirements
- R1: After reset is released, all eight mask bits are 1. A read of port 0Fh or DEh returns 0Fh, and `ctl_clear` is 00.
- R2: A write of any data to port 0Dh (low controller) or DAh (high controller) sets all four mask bits of that controller. `ctl_clear[0]` (low) or `ctl_clear[1]` (high) is then 1 for exactly the one cycle that follows the write cycle.
- R3: A write of any data to port 0Eh (low) or DCh (high) clears all four mask bits of that controller.
- R4: A write to port 0Fh (low) or DEh (high) loads mask bits 3..0 from data bits 3..0. Data bits 7..4 are ignored.
- R5: While `io_rd` is 1, a read of port 0Fh or DEh returns the four mask bits of that controller in bits 3..0 and 0 in bits 7..4. A read of 0Dh, DAh, 0Eh, DCh or any other address returns 00h, and `io_rdata` is 00h whenever `io_rd` is 0.
- R6: A mask bit of 1 blocks its request and a mask bit of 0 passes it. Mask bit n of the low controller belongs to channel n, and mask bit n of the high controller belongs to channel n+4. For channels 7..4, `dreq_eff[n] = dreq[n] & ~mask`.
- R7: While the high controller's bit-0 mask (channel 4) is 1, `dreq_eff[3:0]` is 0 whatever the low masks hold.
- R8: A 1 on `tc_pulse[n]` in a cycle with no register write to that controller sets mask bit n, unless `autoinit[n]` is 1. In that case the mask bit is unchanged.
- R9: When a register write to a controller and a terminal-count pulse on one of its channels fall in the same cycle, the mask takes the value the write gives.
- R10: A write to an address other than the six ports leaves all masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| dreq | input | 8 | Raw DMA requests, channels 7..0 |
| tc_pulse | input | 8 | Terminal-count pulse per channel |
| autoinit | input | 8 | Auto-initialization mode flag per channel |
| dreq_eff | output | 8 | Requests after masking and the cascade rule |
| ctl_clear | output | 2 | Master-clear pulse, bit 0 low controller, bit 1 high |

## Verification
The bench builds the block with its default parameters: four channels per controller, a 16-bit address and the six standard port addresses. With these values both controllers and the cascade path through channel 4 are present. A table of writes walks through the three write operations with reserved data bits set, the cascade override and an unrelated address. Directed tests then cover readback through the mask ports, terminal count with and without auto-initialization, the same-cycle priority of a write over terminal count, and the width of the clear pulse.

// File: rtl/dma_mask_pkg.sv
// Package dma_mask_pkg
// Holds the types shared by the mask logic: the write operation that a port
// decoder hands to a mask bank. Assumes one operation at most per cycle.
package dma_mask_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_MCLR  = 2'd1,
        OP_CLRM  = 2'd2,
        OP_WRALL = 2'd3
    } mask_op_e;
endpackage

// File: rtl/dma_port_decode.sv
// Module dma_port_decode
// Decodes the three I/O ports of one controller into a write operation and
// a read select for the mask readback. Assumes single-cycle strobes.
module dma_port_decode
    import dma_mask_pkg::*;
#(
    parameter int AW         = 16,
    parameter logic [AW-1:0] MCLR_ADDR  = 'h0D,
    parameter logic [AW-1:0] CLRM_ADDR  = 'h0E,
    parameter logic [AW-1:0] WRALL_ADDR = 'h0F
) (
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    output mask_op_e      wr_op,
    output logic          rd_mask
);
    // Write operation selected by address
    always_comb begin
        wr_op = OP_NONE;
        if (io_wr) begin
            if (io_addr == MCLR_ADDR)       wr_op = OP_MCLR;
            else if (io_addr == CLRM_ADDR)  wr_op = OP_CLRM;
            else if (io_addr == WRALL_ADDR) wr_op = OP_WRALL;
        end
    end

    // Only the write-all port has a read path
    assign rd_mask = io_rd && (io_addr == WRALL_ADDR);
endmodule

// File: rtl/dma_mask_bank.sv
// Module dma_mask_bank
// Mask register of one controller. A register write wins over the
// terminal-count auto-set in the same cycle. A master clear also raises a
// registered one-cycle clear pulse. Assumes DW > CH.
module dma_mask_bank
    import dma_mask_pkg::*;
#(
    parameter int CH = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mask_op_e      wr_op,
    input  logic [DW-1:0] wdata,
    input  logic [CH-1:0] tc,
    input  logic [CH-1:0] autoinit,
    output logic [CH-1:0] mask,
    output logic          clr_pulse
);
    localparam logic [CH-1:0] ALL_SET = {CH{1'b1}};

    logic [CH-1:0] tc_set;
    logic [CH-1:0] mask_nxt;

    // Channels that request an auto-set this cycle
    assign tc_set = tc & ~autoinit;

    // Next mask value with write priority
    always_comb begin
        unique case (wr_op)
            OP_MCLR:  mask_nxt = ALL_SET;
            OP_CLRM:  mask_nxt = '0;
            OP_WRALL: mask_nxt = wdata[CH-1:0];
            default:  mask_nxt = mask | tc_set;
        endcase
    end

    // Mask register and clear pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= ALL_SET;
            clr_pulse <= 1'b0;
        end else begin
            mask      <= mask_nxt;
            clr_pulse <= (wr_op == OP_MCLR);
        end
    end
endmodule

// File: rtl/dma_req_gate.sv
// Module dma_req_gate
// Gates the raw requests with the masks. The low controller reaches the
// system through channel CASC of the high controller, so a mask on that
// channel blocks every low channel.
module dma_req_gate #(
    parameter int CH   = 4,
    parameter int CASC = 0
) (
    input  logic [2*CH-1:0] dreq,
    input  logic [CH-1:0]   mask_lo,
    input  logic [CH-1:0]   mask_hi,
    output logic [2*CH-1:0] dreq_eff
);
    logic casc_open;

    // Cascade path open only while its channel is unmasked
    assign casc_open = ~mask_hi[CASC];

    // Per-channel gating
    for (genvar n = 0; n < CH; n++) begin : g_ch
        assign dreq_eff[n]    = dreq[n] & ~mask_lo[n] & casc_open;
        assign dreq_eff[n+CH] = dreq[n+CH] & ~mask_hi[n];
    end
endmodule

// File: rtl/dma_mask_pair.sv
// Module dma_mask_pair
// Top level. It holds one decoder and one mask bank per controller, a shared
// read mux and the request gate. Index 0 is the low controller (channels
// 3..0) and index 1 the high controller (channels 7..4).
module dma_mask_pair
    import dma_mask_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CH = 4,
    parameter logic [AW-1:0] LO_MCLR  = 'h0D,
    parameter logic [AW-1:0] LO_CLRM  = 'h0E,
    parameter logic [AW-1:0] LO_WRALL = 'h0F,
    parameter logic [AW-1:0] HI_MCLR  = 'hDA,
    parameter logic [AW-1:0] HI_CLRM  = 'hDC,
    parameter logic [AW-1:0] HI_WRALL = 'hDE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   io_rdata,
    input  logic [2*CH-1:0] dreq,
    input  logic [2*CH-1:0] tc_pulse,
    input  logic [2*CH-1:0] autoinit,
    output logic [2*CH-1:0] dreq_eff,
    output logic [1:0]      ctl_clear
);
    localparam int NCTL = 2;
    localparam int NCH  = NCTL * CH;

    mask_op_e        wr_op   [NCTL];
    logic [NCTL-1:0] rd_mask;
    logic [CH-1:0]   mask_k  [NCTL];
    logic [NCH-1:0]  mask_all;

    for (genvar k = 0; k < NCTL; k++) begin : g_ctl
        localparam logic [AW-1:0] A_MCLR  = (k == 0) ? LO_MCLR  : HI_MCLR;
        localparam logic [AW-1:0] A_CLRM  = (k == 0) ? LO_CLRM  : HI_CLRM;
        localparam logic [AW-1:0] A_WRALL = (k == 0) ? LO_WRALL : HI_WRALL;

        dma_port_decode #(
            .AW(AW), .MCLR_ADDR(A_MCLR), .CLRM_ADDR(A_CLRM), .WRALL_ADDR(A_WRALL)
        ) u_dec (
            .io_addr (io_addr),
            .io_wr   (io_wr),
            .io_rd   (io_rd),
            .wr_op   (wr_op[k]),
            .rd_mask (rd_mask[k])
        );

        dma_mask_bank #(.CH(CH), .DW(DW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_op     (wr_op[k]),
            .wdata     (io_wdata),
            .tc        (tc_pulse[k*CH +: CH]),
            .autoinit  (autoinit[k*CH +: CH]),
            .mask      (mask_k[k]),
            .clr_pulse (ctl_clear[k])
        );

        assign mask_all[k*CH +: CH] = mask_k[k];
    end

    // Read mux: mask readback, zero elsewhere
    always_comb begin
        io_rdata = '0;
        for (int k = 0; k < NCTL; k++) begin
            if (rd_mask[k]) io_rdata[CH-1:0] = mask_k[k];
        end
    end

    dma_req_gate #(.CH(CH), .CASC(0)) u_gate (
        .dreq     (dreq),
        .mask_lo  (mask_k[0]),
        .mask_hi  (mask_k[1]),
        .dreq_eff (dreq_eff)
    );
endmodule

// File: rtl/dma_mask_pair_chk.sv
// Module dma_mask_pair_chk
// Checker bound into dma_mask_pair. It relates the ports to the internal
// mask vector over time.
module dma_mask_pair_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CH = 4,
    parameter logic [AW-1:0] LO_MCLR  = 'h0D,
    parameter logic [AW-1:0] LO_CLRM  = 'h0E,
    parameter logic [AW-1:0] LO_WRALL = 'h0F,
    parameter logic [AW-1:0] HI_MCLR  = 'hDA,
    parameter logic [AW-1:0] HI_CLRM  = 'hDC,
    parameter logic [AW-1:0] HI_WRALL = 'hDE
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   io_addr,
    input logic            io_wr,
    input logic            io_rd,
    input logic [DW-1:0]   io_rdata,
    input logic [2*CH-1:0] dreq,
    input logic [2*CH-1:0] tc_pulse,
    input logic [2*CH-1:0] autoinit,
    input logic [2*CH-1:0] dreq_eff,
    input logic [1:0]      ctl_clear,
    input logic [2*CH-1:0] mask_all
);
    logic any_port;
    assign any_port = (io_addr == LO_MCLR) || (io_addr == LO_CLRM) ||
                      (io_addr == LO_WRALL) || (io_addr == HI_MCLR) ||
                      (io_addr == HI_CLRM) || (io_addr == HI_WRALL);

    // R7
    cascade_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all[CH] |-> (dreq_eff[CH-1:0] == '0));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_eff & mask_all) == '0);

    // R2
    lo_mclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == LO_MCLR) |=> (mask_all[CH-1:0] == {CH{1'b1}}) && ctl_clear[0]);

    // R2
    hi_mclr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == HI_MCLR) |=> (mask_all[2*CH-1:CH] == {CH{1'b1}}) && ctl_clear[1]);

    // R5
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));

    // R8
    tc_autoset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && (tc_pulse & ~autoinit) != '0) |=>
        ((mask_all & $past(tc_pulse & ~autoinit)) == $past(tc_pulse & ~autoinit)));

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !any_port && tc_pulse == '0) |=> $stable(mask_all));
endmodule

bind dma_mask_pair dma_mask_pair_chk #(
    .AW(AW), .DW(DW), .CH(CH),
    .LO_MCLR(LO_MCLR), .LO_CLRM(LO_CLRM), .LO_WRALL(LO_WRALL),
    .HI_MCLR(HI_MCLR), .HI_CLRM(HI_CLRM), .HI_WRALL(HI_WRALL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .dreq(dreq), .tc_pulse(tc_pulse), .autoinit(autoinit),
    .dreq_eff(dreq_eff), .ctl_clear(ctl_clear), .mask_all(mask_all)
);

// File: tb/sim_dma_mask_pair.sv
module sim_dma_mask_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [7:0]  dreq = '0;
    logic [7:0]  tc_pulse = '0;
    logic [7:0]  autoinit = '0;
    logic [7:0]  dreq_eff;
    logic [1:0]  ctl_clear;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dma_mask_pair u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .tc_pulse(tc_pulse),
        .autoinit(autoinit), .dreq_eff(dreq_eff), .ctl_clear(ctl_clear)
    );

    // Each entry: address, write data, expected dreq_eff with dreq = FFh
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {16'h000E, 8'h00, 8'h00},   // R3 low clear, cascade still masked (R7)
        {16'h00DC, 8'h00, 8'hFF},   // R3 high clear
        {16'h00DE, 8'h01, 8'hE0},   // R7 channel 4 masked
        {16'h00DE, 8'hF2, 8'hDF},   // R4 reserved bits ignored
        {16'h000F, 8'h05, 8'hDA},   // R4 R6 low load
        {16'h00DA, 8'h77, 8'h00},   // R2 high master clear
        {16'h00DE, 8'h00, 8'hFA},   // R6
        {16'h000D, 8'h00, 8'hF0},   // R2 low master clear
        {16'h000E, 8'h33, 8'hFF},   // R3
        {16'h1234, 8'hFF, 8'hFF}    // R10 foreign address
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, io_rdata, exp);
        io_rd = 1'b0; io_addr = '0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        dreq = 8'hFF;
        #1;
        // R1 reset state
        rd_check("R1", 16'h000F, 8'h0F);
        rd_check("R1", 16'h00DE, 8'h0F);
        check("R1", {6'b0, ctl_clear}, 8'h00);
        check("R6", dreq_eff, 8'h00);

        foreach (VEC[i]) begin
            wr(VEC[i][31:16], VEC[i][15:8]);
            check($sformatf("R6 vec%0d", i), dreq_eff, VEC[i][7:0]);
        end

        // R5 readback and zero reads
        wr(16'h000F, 8'hA9);
        wr(16'h00DE, 8'h06);
        rd_check("R5", 16'h000F, 8'h09);
        rd_check("R5", 16'h00DE, 8'h06);
        rd_check("R5", 16'h000D, 8'h00);
        rd_check("R5", 16'h00DC, 8'h00);
        rd_check("R5", 16'h0022, 8'h00);
        io_addr = 16'h000F; #1;
        check("R5", io_rdata, 8'h00);
        io_addr = '0;

        // R6 other request pattern
        wr(16'h000E, 8'h00);
        wr(16'h00DC, 8'h00);
        dreq = 8'h3C; #1;
        check("R6", dreq_eff, 8'h3C);
        wr(16'h00DE, 8'h02);
        check("R6", dreq_eff, 8'h1C);
        wr(16'h00DC, 8'h00);
        dreq = 8'hFF;

        // R8 terminal count without and with auto-init
        tc_pulse = 8'h04;
        @(posedge clk); @(negedge clk);
        tc_pulse = 8'h20; autoinit = 8'h20;
        @(posedge clk); @(negedge clk);
        tc_pulse = '0; autoinit = '0;
        rd_check("R8", 16'h000F, 8'h04);
        rd_check("R8", 16'h00DE, 8'h00);

        // R9 write beats terminal count in the same cycle
        tc_pulse = 8'h40;
        wr(16'h00DE, 8'h00);
        tc_pulse = '0;
        rd_check("R9", 16'h00DE, 8'h00);
        tc_pulse = 8'h02;
        wr(16'h000E, 8'h00);
        tc_pulse = '0;
        rd_check("R9", 16'h000F, 8'h00);

        // R2 clear pulse width and target controller
        io_addr = 16'h00DA; io_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0; io_addr = '0;
        check("R2", {6'b0, ctl_clear}, 8'h02);
        @(posedge clk); @(negedge clk);
        check("R2", {6'b0, ctl_clear}, 8'h00);
        rd_check("R2", 16'h000F, 8'h00);
        rd_check("R2", 16'h00DE, 8'h0F);
        wr(16'h000D, 8'h00);
        check("R2", {6'b0, ctl_clear}, 8'h01);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule